// File: doc/BRIEF.md
# Fan PWM Generator With Edge Points

This block drives one fan PWM pin. A two-stage prescaler divides the system clock into a tick. The high stage divides by a power of two and the low stage divides by one or by an even number. An 8-bit period counter advances on each tick and wraps after `unit + 1` ticks. The output is shaped by two 8-bit edge points inside that period: it goes high at the rise point and low at the fall point. The duty cycle is therefore set by where these two edges fall, not by a single compare value.

Software writes the fields through a small write-only register port. Divider, period and edge fields first land in a staging copy. They move into the active copy only at a period boundary, or at once while the clock-run bit is clear, so that a period is never cut short or stretched mid-way. The channel-on bit acts at once and forces the pin low, which is how zero duty is produced. The clock-run bit starts and stops all counting.

Top module: `fan_pwm_edge`

## Requirements
- R1: After reset `pwm_o` is low, clock-run and channel-on are clear, and every divider, period and edge field is zero.
- R2: The high divider field `h` (4 bits) makes the prescaler divide by 2^h.
- R3: The low divider field `l` (4 bits) divides by 1 when `l` is 0 and by 2*l otherwise. The total division `D` is the product of the high and low stages.
- R4: One PWM period lasts `(unit + 1) * D` clock cycles, where `unit` is the 8-bit period field. The period count runs 0..unit.
- R5: When rise < fall, the output is high for the counts c with rise <= c < fall.
- R6: When the rise point equals the fall point, the enabled output is continuously high (full duty). This includes both points at 0.
- R7: When the fall point is larger than `unit`, the output stays high from the rise point to the end of every period.
- R8: When rise > fall, the high window wraps: the output is high for c >= rise or c < fall.
- R9: Clearing channel-on drives `pwm_o` low from the cycle after the write, and it stays low.
- R10: Clearing clock-run stops the prescaler and period counter, resets them to zero and holds `pwm_o` low. After clock-run is set again, the first period starts at count 0.
- R11: Divider, unit and edge values that are written while running take effect only at the next period boundary. While clock-run is clear they take effect at once.
- R12: Write port map (3-bit address, 8-bit data): address 0 holds bit0 clock-run and bit1 channel-on; address 1 holds bits[3:0] high divider and bits[7:4] low divider; address 2 holds unit; address 3 holds the rise point; address 4 holds the fall point. Other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| pwm_o | output | 1 | Fan PWM output |

## Verification
The bench builds the block with its default widths: 4-bit divider fields and an 8-bit period and edge counter. It programs small divisions (1, 4, 6, 8) and short periods, so each period is only tens of cycles long. This keeps every edge case within a few hundred cycles: plain, wrapped, full and over-range windows, the period-boundary hand-over of a staged fall point, and restart from count zero. The largest division (2^15 * 30) is still reachable from the default widths, but it is covered only by the in-RTL range checks.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  localparam int unsigned HI_W   = 4;
  localparam int unsigned LO_W   = 4;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
  localparam logic [ADDR_W-1:0] A_UNIT = 3'd2;
  localparam logic [ADDR_W-1:0] A_RISE = 3'd3;
  localparam logic [ADDR_W-1:0] A_FALL = 3'd4;

  typedef struct packed {
    logic [HI_W-1:0]  div_hi;
    logic [LO_W-1:0]  div_lo;
    logic [CNT_W-1:0] unit;
    logic [CNT_W-1:0] rise;
    logic [CNT_W-1:0] fall;
  } cfg_t;
endpackage

// File: rtl/fpwm_regs.sv
module fpwm_regs
  import fpwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              run_o,
  output logic              ch_on_o,
  output cfg_t              stage_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      ch_on_o <= 1'b0;
      stage_o <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL: begin
          run_o   <= wr_data_i[0];
          ch_on_o <= wr_data_i[1];
        end
        A_DIV: begin
          stage_o.div_hi <= wr_data_i[HI_W-1:0];
          stage_o.div_lo <= wr_data_i[HI_W+LO_W-1:HI_W];
        end
        A_UNIT:  stage_o.unit <= wr_data_i[CNT_W-1:0];
        A_RISE:  stage_o.rise <= wr_data_i[CNT_W-1:0];
        A_FALL:  stage_o.fall <= wr_data_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler #(
  parameter int unsigned HI_W = 4,
  parameter int unsigned LO_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [HI_W-1:0] div_hi_i,
  input  logic [LO_W-1:0] div_lo_i,
  output logic            tick_o
);
  localparam int unsigned DIV_W = (1 << HI_W) - 1 + LO_W + 1;

  logic [DIV_W-1:0] lo_fac, div_val, term_val, pre_q;

  always_comb begin
    lo_fac   = (div_lo_i == '0) ? DIV_W'(1) : DIV_W'({div_lo_i, 1'b0});
    div_val  = lo_fac << div_hi_i;
    term_val = div_val - DIV_W'(1);
  end

  assign tick_o = run_i && (pre_q == term_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pre_q <= '0;
    else if (!run_i)      pre_q <= '0;
    else if (tick_o)      pre_q <= '0;
    else                  pre_q <= pre_q + DIV_W'(1);
  end

  // R3
  div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q < div_val);
endmodule

// File: rtl/fpwm_period.sv
module fpwm_period
  import fpwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  cfg_t             stage_i,
  output cfg_t             act_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic wrap;
  assign wrap = tick_i && (cnt_o == act_o.unit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      act_o <= '0;
    end else if (!run_i) begin
      cnt_o <= '0;
      act_o <= stage_i;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_o <= '0;
        act_o <= stage_i;
      end else begin
        cnt_o <= cnt_o + CNT_W'(1);
      end
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= act_o.unit);
  // R11
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap) |=> $stable(act_o));
  // R10
  stop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_o == '0));
  // R10
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> run_i);
endmodule

// File: rtl/fpwm_shaper.sv
module fpwm_shaper #(
  parameter int unsigned CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] rise_i,
  input  logic [CNT_W-1:0] fall_i,
  input  logic             run_i,
  input  logic             ch_on_i,
  output logic             pwm_o
);
  logic win;

  always_comb begin
    if (rise_i == fall_i)     win = 1'b1;
    else if (rise_i < fall_i) win = (cnt_i >= rise_i) && (cnt_i < fall_i);
    else                      win = (cnt_i >= rise_i) || (cnt_i < fall_i);
  end

  assign pwm_o = run_i && ch_on_i && win;
endmodule

// File: rtl/fan_pwm_edge.sv
module fan_pwm_edge
  import fpwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pwm_o
);
  logic             run, ch_on, tick;
  cfg_t             stage, act;
  logic [CNT_W-1:0] cnt;

  fpwm_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .run_o(run), .ch_on_o(ch_on), .stage_o(stage)
  );

  fpwm_prescaler #(.HI_W(HI_W), .LO_W(LO_W)) u_pre (
    .clk_i, .rst_ni, .run_i(run),
    .div_hi_i(act.div_hi), .div_lo_i(act.div_lo), .tick_o(tick)
  );

  fpwm_period u_per (
    .clk_i, .rst_ni, .run_i(run), .tick_i(tick),
    .stage_i(stage), .act_o(act), .cnt_o(cnt)
  );

  fpwm_shaper #(.CNT_W(CNT_W)) u_shp (
    .cnt_i(cnt), .rise_i(act.rise), .fall_i(act.fall),
    .run_i(run), .ch_on_i(ch_on), .pwm_o
  );

  // R6
  full_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && ch_on && act.rise == act.fall) |-> pwm_o);
  // R9
  ch_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch_on |-> !pwm_o);
endmodule

// File: tb/fan_pwm_edge_tb.sv
module fan_pwm_edge_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm;
  int         n_run = 0, n_fail = 0;
  int         cyc = 0;

  always #2.5 clk = ~clk;

  fan_pwm_edge u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pwm_o(pwm)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(output bit ok);
    bit prev = pwm;
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!prev && pwm) begin ok = 1'b1; break; end
      prev = pwm;
    end
  endtask

  // measure one period starting at a rising edge
  task automatic measure(output int per, output int hi);
    bit ok, prev;
    per = 0; hi = 0;
    wait_rise(ok);
    if (!ok) return;
    prev = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (i > 0 && !prev && pwm) break;
      if (pwm) hi++;
      per++;
      prev = pwm;
      @(negedge clk);
    end
  endtask

  task automatic setup(input int h, input int l, input int u, input int r, input int f);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'((l << 4) | h));
    wr(3'd2, 8'(u));
    wr(3'd3, 8'(r));
    wr(3'd4, 8'(f));
    wr(3'd0, 8'h03);
  endtask

  task automatic run_shape(input string req, input int h, input int l, input int u,
                           input int r, input int f, input int exp_per, input int exp_hi);
    int per, hi;
    setup(h, l, u, r, f);
    measure(per, hi);
    measure(per, hi);
    check(per == exp_per, {req, " period"}, per, exp_per);
    check(hi == exp_hi, {req, " high"}, hi, exp_hi);
  endtask

  task automatic t_reset;
    // R1
    check(pwm == 1'b0, "R1 reset output", int'(pwm), 0);
    wr(3'd0, 8'h01);
    repeat (3) @(negedge clk);
    check(pwm == 1'b0, "R1 channel off after reset", int'(pwm), 0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_full_duty;
    int lows = 0;
    // R6: both points 0
    setup(0, 0, 9, 0, 0);
    for (int i = 0; i < 60; i++) begin
      if (!pwm) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R6 full duty 0/0", lows, 0);
    lows = 0;
    setup(1, 1, 5, 3, 3);
    for (int i = 0; i < 60; i++) begin
      if (!pwm) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R6 full duty equal points", lows, 0);
  endtask

  task automatic t_ch_off;
    int highs = 0;
    setup(0, 0, 9, 2, 7);
    repeat (4) @(negedge clk);
    wr(3'd0, 8'h01);
    // R9
    for (int i = 0; i < 50; i++) begin
      if (pwm) highs++;
      @(negedge clk);
    end
    check(highs == 0, "R9 channel off", highs, 0);
  endtask

  task automatic t_stop_restart;
    int highs = 0, n = 0;
    setup(0, 0, 9, 0, 3);
    repeat (5) @(negedge clk);
    wr(3'd0, 8'h02);
    // R10: clock stopped
    for (int i = 0; i < 40; i++) begin
      if (pwm) highs++;
      @(negedge clk);
    end
    check(highs == 0, "R10 stopped low", highs, 0);
    wr(3'd0, 8'h03);
    // R10: restart at count 0 gives high for counts 0..2
    while (pwm && n < 100) begin n++; @(negedge clk); end
    check(n == 3, "R10 restart from zero", n, 3);
  endtask

  task automatic t_shadow;
    bit ok;
    int n = 1, per, hi;
    setup(0, 0, 19, 0, 10);
    wait_rise(ok);
    wait_rise(ok);
    wr(3'd4, 8'd15);
    while (pwm && n < 100) begin n++; @(negedge clk); end
    // R11: current period keeps old fall point
    check(n == 10, "R11 current period unchanged", n, 10);
    measure(per, hi);
    check(hi == 15, "R11 new fall at next period", hi, 15);
  endtask

  task automatic t_bad_addr;
    int per, hi;
    setup(0, 0, 9, 2, 5);
    wr(3'd5, 8'hFF);
    wr(3'd7, 8'h00);
    measure(per, hi);
    measure(per, hi);
    // R12: unmapped addresses ignored
    check(per == 10 && hi == 3, "R12 unmapped write ignored", hi, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_shape("R5 R4 basic", 0, 0, 9, 2, 5, 10, 3);
    run_shape("R2 high div", 2, 0, 3, 0, 2, 16, 8);
    run_shape("R3 low div", 0, 3, 4, 1, 3, 30, 12);
    run_shape("R3 R2 cascade", 1, 2, 3, 1, 2, 32, 8);
    run_shape("R7 fall beyond unit", 0, 0, 5, 2, 200, 6, 4);
    run_shape("R8 wrapped window", 0, 0, 7, 6, 2, 8, 4);
    t_full_duty();
    t_ch_off();
    t_stop_restart();
    t_shadow();
    t_bad_addr();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule